// File: doc/BRIEF.md
# Receive-Enable Gate Calibration Sequencer

This block runs the search for the read-strobe gate delay on one memory channel that has four byte-lane groups. It handles one group at a time. It loads a starting delay into an external delay normalizer, then sends single step commands to that normalizer. Between steps it samples the strobe level of the group's two byte lanes through a three-stage handshake: arm the sampler, issue a dummy read, then fetch the level bit.

The search for each group runs in this order:

1. Find a low level.
2. Find the rising edge, first coarsely and then finely.
3. Back off into the preamble.
4. Find the edge again.
5. Make the closing adjustments.

The normalizer owns the delay arithmetic. After every step it returns the normalized delay fields. The sequencer keeps the returned fields of each finished group. When all groups are finished, it moves every group's coarse value down to the common minimum. The amount each group was lowered is kept as that group's preamble offset.

Software configures the block with the CAS latency and the card type, then pulses `start`. When the block finishes, it pulses `done` and the per-group results are held on the result buses. A normalizer error stops the run and leaves `fail` set.

Top module: `rec_cal_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and every request output are low, and all result fields read zero.
- R2: A `start` pulse begins with group 0 and handles groups 0, 1, 2 and 3 in that order. Each group begins with a load command (op 0) whose `norm_load_c` equals `cas_lat` plus 1.
- R3: Each lane sample follows three stages in order. First, `smp_arm` is high for exactly one cycle. Next, `smp_rd_req` stays high until `smp_rd_ack`. Last, `smp_lvl_req` stays high until `smp_lvl_ack`, and `smp_lvl` is captured on that acknowledge. A group sample always reads its first lane and then its second lane.
- R4: `norm_req` stays high with a stable op until `norm_ack`. No sample request is raised while a step is outstanding. The op codes are: 0 load, 1 quarter step, 2 quarter backstep, 3 smallest step, 4 full (coarse) backstep, 5 half backstep, 6 tap plus 2, 7 tap plus 1. Every step except the closing ones of a group is followed by a group sample.
- R5: Low search: after the load, the block issues a quarter step while either lane samples high.
- R6: Edge search: the block issues tap plus 2 and then quarter steps until any lane is high. It then issues one quarter backstep, followed by smallest steps until both lanes are high.
- R7: After the first edge, the block issues one quarter step, then full backsteps while either lane is high. After that it runs the edge search a second time.
- R8: After the second edge, the block issues a half backstep. For the alternate card type it then issues a tap plus 1. The group's result is taken from the normalizer's reply to the last of these.
- R9: When the last group is finished, every `res_coarse` field equals the smallest group coarse value. Each `res_pre` field equals that group's coarse value minus the minimum, truncated to its width.
- R10: For a standard card, group g samples lane 2g and then lane 2g+1. For the alternate card, both samples of groups 0, 1, 2 and 3 come from lanes 0, 3, 6 and 5.
- R11: A normalizer acknowledge with `norm_err` high ends the run at once. `fail` then stays high and `done` is not pulsed until the next `start`, which clears `fail`.
- R12: A successful run ends with `done` high for exactly one cycle, at which point `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin calibration |
| cas_lat | input | 4 | CAS latency; group starting coarse value is this plus 1 |
| alt_card | input | 1 | Alternate card type: changes the lane map and adds the final tap |
| norm_req | output | 1 | Step command valid |
| norm_op | output | 3 | Step command code |
| norm_grp | output | 2 | Group the step applies to |
| norm_load_c | output | 4 | Starting coarse value for a load command |
| norm_ack | input | 1 | Step applied |
| norm_err | input | 1 | Normalized delay left its range |
| norm_c | input | 4 | Normalized coarse value |
| norm_ph | input | 2 | Normalized phase value |
| norm_t | input | 4 | Normalized tap value |
| norm_p | input | 3 | Normalized fine value |
| smp_arm | output | 1 | One-cycle sampler arm strobe |
| smp_lane | output | 3 | Byte lane being sampled |
| smp_rd_req | output | 1 | Dummy read request |
| smp_rd_ack | input | 1 | Dummy read completed |
| smp_lvl_req | output | 1 | Level fetch request |
| smp_lvl_ack | input | 1 | Level valid |
| smp_lvl | input | 1 | Sampled strobe level |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky abort flag |
| res_coarse | output | 16 | Per-group coarse value, group g at bits 4g+3:4g |
| res_pre | output | 8 | Per-group preamble offset, group g at bits 2g+1:2g |
| res_phase | output | 8 | Per-group phase, group g at bits 2g+1:2g |
| res_tap | output | 16 | Per-group tap, group g at bits 4g+3:4g |
| res_fine | output | 12 | Per-group fine value, group g at bits 3g+2:3g |

## Verification
The bench builds the block with its default parameters: four groups, a 4-bit coarse field and a 2-bit preamble offset. These are small enough that a run which does not converge pushes the coarse value past 15 within a few dozen steps, so the error abort can be reached. The normalizer bounds are chosen per run rather than at build time. One setting uses 9 taps and 8 fine units, so every quarter step carries a fine part and fine steps wrap into taps. The other uses 12 taps and 1 fine unit, so every smallest step becomes a tap carry. The strobe model gives each lane its own burst start. This spreads the groups' coarse values enough to give nonzero preamble offsets, and one run starts inside a high half-period so that the low search has to move.

// File: rtl/rec_cal_seq.sv
module rec_cal_seq #(
  parameter int NG    = 4,
  parameter int C_W   = 4,
  parameter int PH_W  = 2,
  parameter int T_W   = 4,
  parameter int P_W   = 3,
  parameter int PRE_W = 2,
  localparam int GRP_W  = $clog2(NG),
  localparam int LANE_W = GRP_W + 1,
  localparam int OP_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [C_W-1:0]        cas_lat,
  input  logic                  alt_card,
  output logic                  norm_req,
  output logic [OP_W-1:0]       norm_op,
  output logic [GRP_W-1:0]      norm_grp,
  output logic [C_W-1:0]        norm_load_c,
  input  logic                  norm_ack,
  input  logic                  norm_err,
  input  logic [C_W-1:0]        norm_c,
  input  logic [PH_W-1:0]       norm_ph,
  input  logic [T_W-1:0]        norm_t,
  input  logic [P_W-1:0]        norm_p,
  output logic                  smp_arm,
  output logic [LANE_W-1:0]     smp_lane,
  output logic                  smp_rd_req,
  input  logic                  smp_rd_ack,
  output logic                  smp_lvl_req,
  input  logic                  smp_lvl_ack,
  input  logic                  smp_lvl,
  output logic                  busy,
  output logic                  done,
  output logic                  fail,
  output logic [NG*C_W-1:0]     res_coarse,
  output logic [NG*PRE_W-1:0]   res_pre,
  output logic [NG*PH_W-1:0]    res_phase,
  output logic [NG*T_W-1:0]     res_tap,
  output logic [NG*P_W-1:0]     res_fine
);

  localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
  localparam logic [OP_W-1:0] OP_QSTEP = 3'd1;
  localparam logic [OP_W-1:0] OP_QBACK = 3'd2;
  localparam logic [OP_W-1:0] OP_FINE  = 3'd3;
  localparam logic [OP_W-1:0] OP_FULLB = 3'd4;
  localparam logic [OP_W-1:0] OP_HALFB = 3'd5;
  localparam logic [OP_W-1:0] OP_TAP2  = 3'd6;
  localparam logic [OP_W-1:0] OP_TAP1  = 3'd7;
  localparam logic [GRP_W-1:0] LAST_G  = GRP_W'(NG - 1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_ARM, S_RD, S_LVL, S_DEC, S_ALIGN} st_t;
  typedef enum logic [2:0] {PH_LOW, PH_CRS, PH_FIN, PH_PRE, PH_HALF, PH_TAPX} phs_t;

  st_t               st;
  phs_t              phs;
  logic              pass2;
  logic [GRP_W-1:0]  grp;
  logic              lane_sel;
  logic [1:0]        hi;
  logic [OP_W-1:0]   op;
  logic [C_W-1:0]    cas_q;
  logic              alt_q;
  logic              done_q;
  logic              fail_q;

  logic [C_W-1:0]    rc   [NG];
  logic [PRE_W-1:0]  rpre [NG];
  logic [PH_W-1:0]   rph  [NG];
  logic [T_W-1:0]    rt   [NG];
  logic [P_W-1:0]    rp   [NG];
  logic [C_W-1:0]    cmin;

  function automatic logic [LANE_W-1:0] alt_lane(input logic [GRP_W-1:0] g);
    case (int'(g))
      0:       alt_lane = LANE_W'(0);
      1:       alt_lane = LANE_W'(3);
      2:       alt_lane = LANE_W'(6);
      3:       alt_lane = LANE_W'(5);
      default: alt_lane = {g, 1'b0};
    endcase
  endfunction

  assign norm_req    = (st == S_STEP);
  assign norm_op     = op;
  assign norm_grp    = grp;
  assign norm_load_c = cas_q + C_W'(1);
  assign smp_arm     = (st == S_ARM);
  assign smp_rd_req  = (st == S_RD);
  assign smp_lvl_req = (st == S_LVL);
  assign smp_lane    = alt_q ? alt_lane(grp) : {grp, lane_sel};
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign fail        = fail_q;

  always_comb begin
    cmin = rc[0];
    for (int g = 1; g < NG; g++)
      if (rc[g] < cmin) cmin = rc[g];
  end

  for (genvar g = 0; g < NG; g++) begin : g_res
    assign res_coarse[g*C_W +: C_W]     = rc[g];
    assign res_pre[g*PRE_W +: PRE_W]    = rpre[g];
    assign res_phase[g*PH_W +: PH_W]    = rph[g];
    assign res_tap[g*T_W +: T_W]        = rt[g];
    assign res_fine[g*P_W +: P_W]       = rp[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phs      <= PH_LOW;
      pass2    <= 1'b0;
      grp      <= '0;
      lane_sel <= 1'b0;
      hi       <= '0;
      op       <= OP_LOAD;
      cas_q    <= '0;
      alt_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      for (int g = 0; g < NG; g++) begin
        rc[g]   <= '0;
        rpre[g] <= '0;
        rph[g]  <= '0;
        rt[g]   <= '0;
        rp[g]   <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cas_q  <= cas_lat;
          alt_q  <= alt_card;
          fail_q <= 1'b0;
          grp    <= '0;
          op     <= OP_LOAD;
          phs    <= PH_LOW;
          pass2  <= 1'b0;
          st     <= S_STEP;
        end
        S_STEP: if (norm_ack) begin
          if (norm_err) begin
            fail_q <= 1'b1;
            st     <= S_IDLE;
          end else if (phs == PH_HALF && alt_q) begin
            op  <= OP_TAP1;
            phs <= PH_TAPX;
          end else if (phs == PH_HALF || phs == PH_TAPX) begin
            rc[grp]   <= norm_c;
            rph[grp]  <= norm_ph;
            rt[grp]   <= norm_t;
            rp[grp]   <= norm_p;
            rpre[grp] <= '0;
            if (grp == LAST_G) begin
              st <= S_ALIGN;
            end else begin
              grp   <= grp + GRP_W'(1);
              op    <= OP_LOAD;
              phs   <= PH_LOW;
              pass2 <= 1'b0;
            end
          end else begin
            lane_sel <= 1'b0;
            st       <= S_ARM;
          end
        end
        S_ARM: st <= S_RD;
        S_RD:  if (smp_rd_ack) st <= S_LVL;
        S_LVL: if (smp_lvl_ack) begin
          hi[lane_sel] <= smp_lvl;
          if (!lane_sel) begin
            lane_sel <= 1'b1;
            st       <= S_ARM;
          end else begin
            st <= S_DEC;
          end
        end
        S_DEC: begin
          st <= S_STEP;
          case (phs)
            PH_LOW:
              if (|hi) op <= OP_QSTEP;
              else begin op <= OP_TAP2; phs <= PH_CRS; end
            PH_CRS:
              if (|hi) begin op <= OP_QBACK; phs <= PH_FIN; end
              else op <= OP_QSTEP;
            PH_FIN:
              if (!(&hi)) op <= OP_FINE;
              else if (!pass2) begin op <= OP_QSTEP; phs <= PH_PRE; end
              else begin op <= OP_HALFB; phs <= PH_HALF; end
            PH_PRE:
              if (|hi) op <= OP_FULLB;
              else begin op <= OP_TAP2; phs <= PH_CRS; pass2 <= 1'b1; end
            default: op <= op;
          endcase
        end
        S_ALIGN: begin
          for (int g = 0; g < NG; g++) begin
            rpre[g] <= PRE_W'(rc[g] - cmin);
            rc[g]   <= cmin;
          end
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rec_cal_seq_chk.sv
module rec_cal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic norm_req,
  input logic norm_ack,
  input logic norm_err,
  input logic smp_arm,
  input logic smp_rd_req,
  input logic smp_rd_ack,
  input logic smp_lvl_req,
  input logic busy,
  input logic done,
  input logic fail
);

  // R4
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req && !norm_ack |=> norm_req);

  // R4
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({norm_req, smp_arm, smp_rd_req, smp_lvl_req}));

  // R4
  step_then_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req && norm_ack && !norm_err |=> !smp_rd_req && !smp_lvl_req);

  // R3
  arm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_arm |=> !smp_arm && smp_rd_req);

  // R3
  read_then_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rd_req && smp_rd_ack |=> smp_lvl_req);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !fail);

  // R11
  fail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !busy);

  // R11
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req && norm_ack && norm_err |=> fail && !busy);

endmodule

bind rec_cal_seq rec_cal_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .norm_req(norm_req), .norm_ack(norm_ack),
  .norm_err(norm_err), .smp_arm(smp_arm), .smp_rd_req(smp_rd_req),
  .smp_rd_ack(smp_rd_ack), .smp_lvl_req(smp_lvl_req), .busy(busy),
  .done(done), .fail(fail)
);

// File: tb/rec_cal_seq_tb_top.sv
`timescale 1ns/1ps
module rec_cal_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cas_lat = '0;
  logic alt_card = 1'b0;
  logic norm_req;
  logic [2:0] norm_op;
  logic [1:0] norm_grp;
  logic [3:0] norm_load_c;
  logic norm_ack = 1'b0, norm_err = 1'b0;
  logic [3:0] norm_c = '0;
  logic [1:0] norm_ph = '0;
  logic [3:0] norm_t = '0;
  logic [2:0] norm_p = '0;
  logic smp_arm;
  logic [2:0] smp_lane;
  logic smp_rd_req, smp_lvl_req;
  logic smp_rd_ack = 1'b0, smp_lvl_ack = 1'b0, smp_lvl = 1'b0;
  logic busy, done, fail;
  logic [15:0] res_coarse;
  logic [7:0]  res_pre;
  logic [7:0]  res_phase;
  logic [15:0] res_tap;
  logic [11:0] res_fine;

  always #2 clk = ~clk;

  rec_cal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cas_lat(cas_lat), .alt_card(alt_card),
    .norm_req(norm_req), .norm_op(norm_op), .norm_grp(norm_grp), .norm_load_c(norm_load_c),
    .norm_ack(norm_ack), .norm_err(norm_err), .norm_c(norm_c), .norm_ph(norm_ph),
    .norm_t(norm_t), .norm_p(norm_p), .smp_arm(smp_arm), .smp_lane(smp_lane),
    .smp_rd_req(smp_rd_req), .smp_rd_ack(smp_rd_ack), .smp_lvl_req(smp_lvl_req),
    .smp_lvl_ack(smp_lvl_ack), .smp_lvl(smp_lvl), .busy(busy), .done(done), .fail(fail),
    .res_coarse(res_coarse), .res_pre(res_pre), .res_phase(res_phase),
    .res_tap(res_tap), .res_fine(res_fine)
  );

  int checks = 0;
  int errors = 0;
  int tb_v, pb_v, cas_v;
  bit alt_v;
  int s_l[8];
  int op_q[$];
  string tag_q[$];
  int lane_q[$];
  int ec[4], epre[4], eph[4], et[4], ep[4];
  bit exp_fail;
  int bc[4], bph[4], bt[4], bp[4];
  int cur_g = 0;
  bit prev_arm = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int amap(input int g);
    case (g) 0: return 0; 1: return 3; 2: return 6; default: return 5; endcase
  endfunction

  function automatic bit lvl_of(input int lane, input int c, input int ph, input int t, input int p);
    int pos, k, hp;
    hp  = tb_v * pb_v;
    pos = ((c * 2 + ph / 2) * tb_v + t) * pb_v + p;
    if (pos < s_l[lane]) return 0;
    k = (pos - s_l[lane]) / hp;
    return (k < 8) && (k % 2 == 0);
  endfunction

  task automatic apply(input int op, inout int c, inout int ph, inout int t, inout int p, output bit e);
    case (op)
      1: begin t += tb_v >> 1; p += (tb_v & 1) * (pb_v >> 1); end
      2: begin t -= tb_v >> 1; p -= (tb_v & 1) * (pb_v >> 1); end
      3: p += 1;
      4: c -= 1;
      5: ph -= 2;
      6: t += 2;
      7: t += 1;
      default: ;
    endcase
    while (p >= pb_v) begin t++; p -= pb_v; end
    while (p < 0) begin t--; p += pb_v; end
    while (t >= tb_v) begin ph += 2; t -= tb_v; end
    while (t < 0) begin ph -= 2; t += tb_v; end
    while (ph >= 4) begin c++; ph -= 4; end
    while (ph < 0) begin c--; ph += 4; end
    e = (c < 0) || (c >= 16);
  endtask

  task automatic rop(input int op, input string tag, inout int c, inout int ph, inout int t, inout int p);
    bit e;
    op_q.push_back(op);
    tag_q.push_back(tag);
    apply(op, c, ph, t, p, e);
    if (e) exp_fail = 1;
  endtask

  task automatic rsmp(input int g, input int c, input int ph, input int t, input int p, output bit h0, output bit h1);
    int la, lb;
    la = alt_v ? amap(g) : 2 * g;
    lb = alt_v ? amap(g) : 2 * g + 1;
    lane_q.push_back(la);
    lane_q.push_back(lb);
    h0 = lvl_of(la, c, ph, t, p);
    h1 = lvl_of(lb, c, ph, t, p);
  endtask

  // behavioural reference of the whole search: expected op stream, lanes and results
  task automatic ref_run();
    int c, ph, t, p, mn;
    bit h0, h1;
    exp_fail = 0;
    for (int g = 0; g < 4; g++) begin
      if (exp_fail) break;
      c = cas_v + 1; ph = 0; t = 0; p = 0;
      rop(0, "R2", c, ph, t, p);
      rsmp(g, c, ph, t, p, h0, h1);
      while (!exp_fail && (h0 || h1)) begin
        rop(1, "R5", c, ph, t, p);
        if (!exp_fail) rsmp(g, c, ph, t, p, h0, h1);
      end
      for (int pass = 0; pass < 2; pass++) begin
        if (exp_fail) break;
        rop(6, "R6", c, ph, t, p);
        if (!exp_fail) rsmp(g, c, ph, t, p, h0, h1);
        while (!exp_fail && !(h0 || h1)) begin
          rop(1, "R6", c, ph, t, p);
          if (!exp_fail) rsmp(g, c, ph, t, p, h0, h1);
        end
        if (!exp_fail) rop(2, "R6", c, ph, t, p);
        if (!exp_fail) rsmp(g, c, ph, t, p, h0, h1);
        while (!exp_fail && !(h0 && h1)) begin
          rop(3, "R6", c, ph, t, p);
          if (!exp_fail) rsmp(g, c, ph, t, p, h0, h1);
        end
        if (pass == 0 && !exp_fail) begin
          rop(1, "R7", c, ph, t, p);
          if (!exp_fail) rsmp(g, c, ph, t, p, h0, h1);
          while (!exp_fail && (h0 || h1)) begin
            rop(4, "R7", c, ph, t, p);
            if (!exp_fail) rsmp(g, c, ph, t, p, h0, h1);
          end
        end
      end
      if (!exp_fail) rop(5, "R8", c, ph, t, p);
      if (!exp_fail && alt_v) rop(7, "R8", c, ph, t, p);
      ec[g] = c; eph[g] = ph; et[g] = t; ep[g] = p;
    end
    if (!exp_fail) begin
      mn = ec[0];
      for (int g = 1; g < 4; g++) if (ec[g] < mn) mn = ec[g];
      for (int g = 0; g < 4; g++) begin
        epre[g] = (ec[g] - mn) & 3;
        ec[g] = mn;
      end
    end
  endtask

  // responder for normalizer and sampler, compared against the reference every clock
  initial begin
    forever begin
      @(negedge clk);
      if (norm_req && !norm_ack) begin
        int op;
        string tg;
        bit e;
        int g;
        g = int'(norm_grp);
        if (op_q.size() == 0) begin
          chk(0, "R4", "unexpected step op", int'(norm_op), -1);
          op = int'(norm_op); tg = "R4";
        end else begin
          op = op_q.pop_front(); tg = tag_q.pop_front();
          chk(int'(norm_op) == op, tg, "step op", int'(norm_op), op);
        end
        if (norm_op == 3'd0) begin
          chk(int'(norm_load_c) == cas_v + 1, "R2", "load coarse", int'(norm_load_c), cas_v + 1);
          bc[g] = int'(norm_load_c); bph[g] = 0; bt[g] = 0; bp[g] = 0;
        end
        apply(int'(norm_op), bc[g], bph[g], bt[g], bp[g], e);
        cur_g = g;
        norm_c = 4'(bc[g]); norm_ph = 2'(bph[g]); norm_t = 4'(bt[g]); norm_p = 3'(bp[g]);
        norm_err = e;
        norm_ack = 1'b1;
      end else begin
        norm_ack = 1'b0;
        norm_err = 1'b0;
      end
      if (smp_arm) begin
        int l;
        l = (lane_q.size() != 0) ? lane_q.pop_front() : -1;
        chk(int'(smp_lane) == l, "R10", "sampled lane", int'(smp_lane), l);
        chk(!prev_arm, "R3", "arm strobe width", 2, 1);
      end
      prev_arm = smp_arm;
      smp_rd_ack = smp_rd_req && !smp_rd_ack;
      if (smp_lvl_req && !smp_lvl_ack) begin
        smp_lvl = lvl_of(int'(smp_lane), bc[cur_g], bph[cur_g], bt[cur_g], bp[cur_g]);
        smp_lvl_ack = 1'b1;
      end else begin
        smp_lvl_ack = 1'b0;
      end
    end
  end

  task automatic run_case(input int cas, input bit alt, input int tb, input int pb);
    int dn, cyc;
    cas_v = cas; alt_v = alt; tb_v = tb; pb_v = pb;
    op_q.delete(); tag_q.delete(); lane_q.delete();
    ref_run();
    @(negedge clk);
    cas_lat = 4'(cas); alt_card = alt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0; cyc = 0;
    while (!done && !fail && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (done) dn = 1;
    chk(cyc < 20000, "R12", "run finished", cyc, 0);
    chk(fail == exp_fail, "R11", "fail flag", fail, exp_fail);
    chk(!busy, "R12", "idle at end", busy, 0);
    chk(op_q.size() == 0, "R4", "ops left unissued", op_q.size(), 0);
    if (!exp_fail) begin
      chk(dn == 1, "R12", "done pulse", dn, 1);
      @(negedge clk);
      chk(!done, "R12", "done one cycle", done, 0);
      for (int g = 0; g < 4; g++) begin
        chk(int'(res_coarse[g*4 +: 4]) == ec[g], "R9", "coarse", int'(res_coarse[g*4 +: 4]), ec[g]);
        chk(int'(res_pre[g*2 +: 2]) == epre[g], "R9", "preamble offset", int'(res_pre[g*2 +: 2]), epre[g]);
        chk(int'(res_phase[g*2 +: 2]) == eph[g], "R8", "phase", int'(res_phase[g*2 +: 2]), eph[g]);
        chk(int'(res_tap[g*4 +: 4]) == et[g], "R8", "tap", int'(res_tap[g*4 +: 4]), et[g]);
        chk(int'(res_fine[g*3 +: 3]) == ep[g], "R8", "fine", int'(res_fine[g*3 +: 3]), ep[g]);
      end
    end else begin
      repeat (5) @(negedge clk);
      chk(fail && !done, "R11", "fail sticky, no done", {fail, done}, 2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fail, "R1", "status after reset", {busy, done, fail}, 0);
    chk(!norm_req && !smp_arm && !smp_rd_req && !smp_lvl_req, "R1", "requests after reset",
        {norm_req, smp_arm, smp_rd_req, smp_lvl_req}, 0);
    chk(res_coarse == '0 && res_pre == '0 && res_phase == '0 && res_tap == '0 && res_fine == '0,
        "R1", "results after reset", int'(res_coarse), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R1", "idle without start", busy, 0);

    // standard card, staggered groups: R5 R6 R7 R8 R9 R10
    for (int l = 0; l < 8; l++) s_l[l] = 150 + (l / 2) * 24 + (l % 2) * 3;
    run_case(5, 1'b0, 12, 1);

    // alternate card, fine-bearing quarter steps: R8 R10
    for (int l = 0; l < 8; l++) s_l[l] = 760 + l * 40;
    run_case(4, 1'b1, 9, 8);

    // start inside a high half-period so the low search moves: R5
    for (int l = 0; l < 8; l++) s_l[l] = 138 + l * 3;
    run_case(5, 1'b0, 12, 1);

    // unreachable strobe: coarse overflows, R11
    for (int l = 0; l < 8; l++) s_l[l] = 100000;
    run_case(5, 1'b0, 12, 1);

    // new start clears fail: R11
    for (int l = 0; l < 8; l++) s_l[l] = 150 + (l / 2) * 24 + (l % 2) * 3;
    run_case(5, 1'b0, 12, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule